// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a serial management master for Ethernet PHYs. Software writes one 32-bit maintenance word that holds a complete management frame: start code, opcode, PHY address, register address, turnaround and 16 data bits. The controller sends a 32-bit run of ones as preamble, then shifts the word out MSB first on the management data line. It generates the management clock from the system clock and clears its idle flag for the whole frame.

For a read frame, the controller releases the data line from the second turnaround bit onward. It samples the 16 bits the PHY returns and writes them into the low half of the maintenance word, so software reads the result from the same register it wrote. The management clock ratio is set by a 3-bit code that selects from a fixed table of divisors. Some of those divisors are not powers of two. The port works only while its enable input is high.

Top module: `mdio_master`

## Requirements
- R1: After reset, `idle` is 1, `mdc` is 0, `mdio_oe` is 0 and `maint_word` is all zeros.
- R2: When `mdio_en` is 1, `idle` is 1 and `wr_en` is sampled high, `wr_data` is loaded into `maint_word` and `idle` goes low on the next cycle. `idle` returns high exactly 64×D clock cycles after the accepting edge, where D is the selected divisor.
- R3: The `div_sel` code is latched when a frame starts. Codes 0 to 7 give D = 8, 16, 32, 48, 64, 96, 128 and 224. `mdc` is high for D/2 cycles and low for D/2 cycles.
- R4: The frame holds 64 bit periods: 32 ones, then `maint_word` bits 31 down to 0. `mdio_o` changes only on a falling edge of `mdc` and is stable at every rising edge.
- R5: A read frame has bits 29:28 of the word equal to 2'b10. For a read frame, `mdio_oe` is 1 for bit periods 0 to 46 and 0 for periods 47 to 63. For any other opcode, `mdio_oe` is 1 for all 64 periods.
- R6: At the end of a read frame, the 16 values of `mdio_i` sampled at the rising edges of periods 48 to 63 replace `maint_word[15:0]`, first sample in bit 15. Bits 31:16 are unchanged. A non-read frame leaves `maint_word` unchanged.
- R7: A `wr_en` pulse while a frame is in progress is ignored. The word, the frame on the line and the frame length are unaffected.
- R8: While `mdio_en` is 0, writes are ignored. Dropping `mdio_en` during a frame abandons it: `idle` is 1 and `mdc` is 0 on the next cycle.
- R9: `mdc` is 0 whenever `idle` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdio_en | input | 1 | Management port enable |
| div_sel | input | 3 | Management clock divisor code |
| wr_en | input | 1 | Maintenance word write strobe |
| wr_data | input | 32 | Maintenance word write value |
| maint_word | output | 32 | Current maintenance word, with read data after a read |
| idle | output | 1 | High when no frame is in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output value |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input |

## Verification
The assertions check on every cycle that:
- `mdc` rests low when idle;
- an accepted write makes the block busy;
- the divider count stays inside its half period;
- the data output, the output enable and the word change only at a falling `mdc` edge;
- the upper half of the word holds throughout a frame.

Only the bench scenarios can show:
- the exact frame length for each of the eight divisors;
- the bit content and order on the line;
- the turnaround release point;
- the placement of the captured read data;
- that a mid-frame write, a disabled write and an abort leave the word and the line as specified.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int WORD_W    = 32;
  localparam int DATA_W    = 16;
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = PRE_LEN + WORD_W;
  localparam int BIT_W     = $clog2(FRAME_LEN);
  localparam int SEL_W     = 3;
  localparam int DIV_W     = 8;
  localparam int HALF_W    = DIV_W - 1;
  localparam int OP_HI     = 29;
  localparam int OP_LO     = 28;
  localparam logic [1:0] OP_READ = 2'b10;

  function automatic logic [DIV_W-1:0] div_of(input logic [SEL_W-1:0] code);
    case (code)
      3'd0:    div_of = 8'd8;
      3'd1:    div_of = 8'd16;
      3'd2:    div_of = 8'd32;
      3'd3:    div_of = 8'd48;
      3'd4:    div_of = 8'd64;
      3'd5:    div_of = 8'd96;
      3'd6:    div_of = 8'd128;
      default: div_of = 8'd224;
    endcase
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             start,
  input  logic [SEL_W-1:0] sel,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  logic [SEL_W-1:0]  sel_q;
  logic [HALF_W-1:0] cnt_q, cnt_d;
  logic              mdc_q, mdc_d;
  logic [DIV_W-1:0]  half;
  logic              tick;

  assign half = div_of(sel_q) >> 1;
  assign tick = run && ({1'b0, cnt_q} == (half - 8'd1));

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      if (start) sel_q <= sel;
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc  = mdc_q;
  assign rise = tick && !mdc_q;
  assign fall = tick && mdc_q;

  a_r3_half_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ({1'b0, cnt_q} < half));
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rise,
  input  logic              fall,
  input  logic              mdio_i,
  output logic [WORD_W-1:0] word,
  output logic              busy,
  output logic              start,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam int TA2_IDX    = PRE_LEN + WORD_W - 1 - DATA_W;
  localparam int DATA_START = TA2_IDX + 1;

  logic [WORD_W-1:0] word_q, word_d;
  logic [DATA_W-1:0] cap_q, cap_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic              busy_q, busy_d;
  logic              is_rd;
  logic [4:0]        wsel;

  assign is_rd = (word_q[OP_HI:OP_LO] == OP_READ);
  assign start = wr_en && en && !busy_q;

  always_comb begin
    word_d = word_q;
    cap_d  = cap_q;
    bit_d  = bit_q;
    busy_d = busy_q;
    if (!en) begin
      busy_d = 1'b0;
    end else if (start) begin
      busy_d = 1'b1;
      word_d = wr_data;
      bit_d  = '0;
    end else if (busy_q) begin
      if (rise && (bit_q >= BIT_W'(DATA_START)))
        cap_d = {cap_q[DATA_W-2:0], mdio_i};
      if (fall) begin
        if (bit_q == BIT_W'(FRAME_LEN - 1)) begin
          busy_d = 1'b0;
          if (is_rd) word_d[DATA_W-1:0] = cap_q;
        end else begin
          bit_d = bit_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cap_q  <= '0;
      bit_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      word_q <= word_d;
      cap_q  <= cap_d;
      bit_q  <= bit_d;
      busy_q <= busy_d;
    end
  end

  assign wsel    = 5'(WORD_W - 1) - 5'(bit_q - BIT_W'(PRE_LEN));
  assign mdio_o  = (bit_q < BIT_W'(PRE_LEN)) ? 1'b1 : word_q[wsel];
  assign mdio_oe = busy_q && !(is_rd && (bit_q >= BIT_W'(TA2_IDX)));
  assign word    = word_q;
  assign busy    = busy_q;

  a_r7_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(word_q[WORD_W-1:DATA_W]));
  a_r4_out_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fall) |=> $stable(mdio_o));
  a_r5_oe_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && en && !fall) |=> $stable(mdio_oe));
  a_r6_word_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fall) |=> $stable(word_q));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdio_en,
  input  logic [SEL_W-1:0]  div_sel,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] maint_word,
  output logic              idle,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic busy, start, rise, fall, run;

  assign run = busy && mdio_en;

  mdio_mdc_gen u_mdc (
    .clk(clk), .rst_n(rst_n), .run(run), .start(start), .sel(div_sel),
    .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_frame_eng u_eng (
    .clk(clk), .rst_n(rst_n), .en(mdio_en), .wr_en(wr_en), .wr_data(wr_data),
    .rise(rise), .fall(fall), .mdio_i(mdio_i), .word(maint_word),
    .busy(busy), .start(start), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  assign idle = !busy;

  a_r9_mdc_idle: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !mdc);
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && wr_en && mdio_en) |=> !idle);
endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb_top;
  logic        clk, rst_n, mdio_en, wr_en, mdio_i;
  logic [2:0]  div_sel;
  logic [31:0] wr_data, maint_word;
  logic        idle, mdc, mdio_o, mdio_oe;

  int total = 0;
  int bad = 0;
  int rcnt = 0;
  logic [15:0] phy_rd = '0;
  logic obit [64];
  logic oebit [64];

  // entry = {div code, word written, PHY read data}
  localparam logic [50:0] VEC [8] = '{
    {3'd0, 2'b01, 2'b10, 5'h03, 5'h01, 2'b10, 16'h0000, 16'h796D},
    {3'd1, 2'b01, 2'b01, 5'h1F, 5'h00, 2'b10, 16'hA5C3, 16'hFFFF},
    {3'd3, 2'b01, 2'b10, 5'h00, 5'h1F, 2'b10, 16'h1234, 16'h8001},
    {3'd5, 2'b01, 2'b01, 5'h0A, 5'h15, 2'b10, 16'h0000, 16'h5555},
    {3'd7, 2'b01, 2'b10, 5'h11, 5'h02, 2'b10, 16'hFFFF, 16'h0000},
    {3'd2, 2'b01, 2'b01, 5'h05, 5'h0E, 2'b10, 16'h0F0F, 16'h1111},
    {3'd4, 2'b01, 2'b10, 5'h1E, 5'h09, 2'b10, 16'h00FF, 16'hC3A5},
    {3'd6, 2'b01, 2'b01, 5'h07, 5'h1B, 2'b10, 16'h8421, 16'h2222}
  };

  mdio_master dut_i (
    .clk(clk), .rst_n(rst_n), .mdio_en(mdio_en), .div_sel(div_sel),
    .wr_en(wr_en), .wr_data(wr_data), .maint_word(maint_word), .idle(idle),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // PHY model: record the line at each rising mdc, drive next read bit
  always @(posedge mdc) begin
    if (rcnt < 64) begin
      obit[rcnt]  = mdio_o;
      oebit[rcnt] = mdio_oe;
    end
    rcnt = rcnt + 1;
    mdio_i = (rcnt >= 48 && rcnt <= 63) ? phy_rd[63 - rcnt] : 1'b1;
  end

  function automatic int divisor(input logic [2:0] c);
    case (c)
      3'd0: return 8;   3'd1: return 16;  3'd2: return 32;  3'd3: return 48;
      3'd4: return 64;  3'd5: return 96;  3'd6: return 128; default: return 224;
    endcase
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [2:0] code, input logic [31:0] w,
                           input logic [15:0] rd, input bit poke);
    int n;
    int d;
    int err_pre;
    int err_word;
    int err_oe;
    bit is_rd;
    logic [31:0] expw;
    d = divisor(code);
    is_rd = (w[29:28] == 2'b10);
    expw = is_rd ? {w[31:16], rd} : w;
    err_pre = 0; err_word = 0; err_oe = 0;
    @(negedge clk);
    rcnt = 0;
    phy_rd = rd;
    div_sel = code;
    wr_data = w;
    wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    chk(!idle, "R2 idle low after write", {31'b0, idle}, 32'h0);
    chk(maint_word == w, "R2 word loaded", maint_word, w);
    n = 0;
    while (1) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (poke && n == 200) begin
        wr_en = 1'b1;
        wr_data = ~w;
      end else begin
        wr_en = 1'b0;
      end
      if (poke && n == 202)
        chk(maint_word == w, "R7 busy write ignored", maint_word, w);
      if (idle || n > 20000) break;
    end
    chk(n == 64 * d, "R2 R3 frame length", n, 64 * d);
    chk(rcnt == 64, "R3 mdc rising count", rcnt, 64);
    for (int i = 0; i < 64; i++) begin
      logic exo;
      logic exb;
      exo = !(is_rd && i >= 47);
      exb = (i < 32) ? 1'b1 : w[63 - i];
      if (oebit[i] !== exo) err_oe++;
      if (exo && obit[i] !== exb) begin
        if (i < 32) err_pre++; else err_word++;
      end
    end
    chk(err_pre == 0, "R4 preamble ones", err_pre, 0);
    chk(err_word == 0, poke ? "R7 R4 word bits on line" : "R4 word bits on line",
        err_word, 0);
    chk(err_oe == 0, "R5 output enable pattern", err_oe, 0);
    chk(maint_word == expw, is_rd ? "R6 read data captured" : "R6 write keeps word",
        maint_word, expw);
    chk(mdc == 1'b0, "R9 mdc low when idle", {31'b0, mdc}, 32'h0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mdio_en = 1'b1; wr_en = 1'b0; wr_data = '0;
    div_sel = '0; mdio_i = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(idle == 1'b1, "R1 idle after reset", {31'b0, idle}, 32'h1);
    chk(mdc == 1'b0, "R1 mdc after reset", {31'b0, mdc}, 32'h0);
    chk(mdio_oe == 1'b0, "R1 oe after reset", {31'b0, mdio_oe}, 32'h0);
    chk(maint_word == 32'h0, "R1 word after reset", maint_word, 32'h0);

    for (int k = 0; k < 8; k++)
      run_frame(VEC[k][50:48], VEC[k][47:16], VEC[k][15:0], 1'b0);

    // R7: write during a frame
    run_frame(3'd0, 32'h6A0A_BEEF, 16'h0000, 1'b1);

    // R8: abort by dropping enable
    @(negedge clk);
    div_sel = 3'd1; wr_data = 32'h5012_3456; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    repeat (300) @(negedge clk);
    mdio_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(idle == 1'b1, "R8 abort sets idle", {31'b0, idle}, 32'h1);
    chk(mdc == 1'b0, "R8 abort stops mdc", {31'b0, mdc}, 32'h0);

    // R8: write while disabled
    wr_data = 32'h6FFF_0001; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    chk(maint_word == 32'h5012_3456, "R8 disabled write ignored", maint_word,
        32'h5012_3456);
    begin
      int toggles;
      toggles = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (mdc || !idle) toggles++;
      end
      chk(toggles == 0, "R8 R9 quiet while disabled", toggles, 0);
    end
    mdio_en = 1'b1;
    run_frame(3'd0, 32'h6842_0000, 16'hBEAD, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule